// File: doc/BRIEF.md
# Serial Pattern Receiver with Bit and Error Counters

The receiver takes a serial test stream one bit per accepted transfer and checks it against a reference that it rebuilds from the incoming bits. While it hunts for alignment it loads its reference shift register straight from the received data. Once enough bits in a row agree with the prediction, it declares lock and runs the reference on its own, so that corrupted bits cannot spoil it. While locked it counts every received bit and every bit that disagrees with the prediction. On request it moves both counts to readable registers, or it takes a snapshot of the last 32 received bits.

The reference follows the shared pattern settings. In repetitive mode the expected bit equals the bit received `cfg_len+1` positions earlier. In pseudorandom mode that bit is additionally XORed with the bit `cfg_tap+1` positions earlier. The receive path can take its data from the transmit stream (loopback) and can complement it. Resynchronisation happens in two ways: automatically, when too many errors arrive inside a window, or on command.

The input stream uses a valid/ready handshake. `rx_ready` is held high permanently, so the block never applies back-pressure, and a bit is consumed in exactly those cycles in which `rx_valid` is high. All control and status pins are plain levels.

Top module: `patrx_top`

## Requirements
- R1: After reset, `bit_count`, `err_count` and `rx_capture` are zero, `locked` is 0 and `rx_ready` is 1.
- R2: While hunting, each received bit is shifted into the reference (newest at bit 0). The predicted bit is `ref[cfg_len]` when `cfg_prbs`=0, and `ref[cfg_len] ^ ref[cfg_tap]` when `cfg_prbs`=1. `locked` rises on the 32nd consecutive matching bit, and never earlier than 32 bits after hunting begins.
- R3: A rising edge of the latch request copies the internal bit and error counts to `bit_count`/`err_count` and clears the internal counts. A bit accepted in that same cycle is counted in the new interval. Without a latch edge, the outputs hold their values.
- R4: The internal counts advance only for bits accepted while `locked`=1. An error is a received bit that differs from the prediction. Both counts stop at all ones.
- R5: Latch, capture and resync each act only on a 0-to-1 transition of their request. The latch request is `latch_ctl | latch_pin` and the capture request is `capture_ctl | capture_pin`. A request held high, or raised on one source while the other source is already high, does nothing.
- R6: A rising edge of the capture request loads `rx_capture` with the last 32 accepted bits, with the newest at bit 0.
- R7: With `cfg_rx_invert`=1, the received bit is complemented before comparison, counting and capture.
- R8: With `cfg_loopback`=1, `rx_bit` is ignored and `tx_bit` is used as the received data.
- R9: While locked with `cfg_auto_off`=0, the receiver returns to hunting when the 6th error falls within one 64-bit window. With `cfg_auto_off`=1, errors never cause a loss of lock.
- R10: A rising edge on `resync_req` returns the receiver to hunting, so `locked` is 0 in the next cycle.
- R11: `rx_ready` is always 1. Bits are taken only in cycles with `rx_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial receive data |
| rx_valid | input | 1 | Receive bit valid |
| rx_ready | output | 1 | Always 1; no back-pressure |
| tx_bit | input | 1 | Transmit stream bit, used in loopback |
| cfg_loopback | input | 1 | 1 = take data from `tx_bit` |
| cfg_rx_invert | input | 1 | 1 = complement received data |
| cfg_auto_off | input | 1 | 1 = disable automatic resync |
| cfg_prbs | input | 1 | 0 = repetitive, 1 = pseudorandom |
| cfg_len | input | 5 | Pattern length minus one |
| cfg_tap | input | 5 | Feedback tap position minus one |
| resync_req | input | 1 | Manual resync request (edge) |
| latch_ctl | input | 1 | Count latch, register source |
| latch_pin | input | 1 | Count latch, pin source |
| capture_ctl | input | 1 | Capture, register source |
| capture_pin | input | 1 | Capture, pin source |
| bit_count | output | CNT_W | Latched bit count |
| err_count | output | CNT_W | Latched error count |
| rx_capture | output | 32 | Captured last 32 bits |
| locked | output | 1 | Synchronised flag |

## Verification
A latch edge can fall in the same cycle as an accepted, counted bit. The bench provokes this by raising `latch_pin` together with `rx_valid`. It expects the latched count to exclude that bit, and the next latch to report exactly 1. It also provokes a latch or capture edge raised while the other source is already high, and expects `bit_count` and `rx_capture` to stay unchanged. A second, narrow-counter instance shares all inputs and is used to judge saturation at all ones.

// File: rtl/patrx_pkg.sv
package patrx_pkg;
  localparam int REF_W = 32;
  localparam int LEN_W = $clog2(REF_W);
  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} sync_state_e;
endpackage

// File: rtl/patrx_rise.sv
module patrx_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rise
);
  logic req_q;
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end
  assign rise = req & ~req_q;
endmodule

// File: rtl/patrx_sync.sv
module patrx_sync
  import patrx_pkg::*;
#(
  parameter int SYNC_MATCHES = 32,
  parameter int WIN_LEN      = 64,
  parameter int ERR_THRESH   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             cfg_prbs,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [LEN_W-1:0] cfg_tap,
  input  logic             cfg_auto_off,
  input  logic             resync_rise,
  output logic             locked,
  output logic             count_en,
  output logic             mismatch
);
  localparam int MW = $clog2(SYNC_MATCHES);
  localparam int WW = $clog2(WIN_LEN);
  localparam int EW = $clog2(ERR_THRESH + 1);
  localparam logic [MW-1:0] M_LAST = MW'(SYNC_MATCHES - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WIN_LEN - 1);
  localparam logic [EW-1:0] E_MAX  = EW'(ERR_THRESH);

  sync_state_e      state_q;
  logic [REF_W-1:0] ref_q;
  logic [MW-1:0]    mcnt_q;
  logic [WW-1:0]    wcnt_q;
  logic [EW-1:0]    werr_q;
  logic             pred;
  logic             err_hit;

  assign pred     = ref_q[cfg_len] ^ (cfg_prbs & ref_q[cfg_tap]);
  assign mismatch = bit_in ^ pred;
  assign locked   = (state_q == ST_LOCK);
  assign count_en = bit_en & locked;
  assign err_hit  = mismatch && ((int'(werr_q) + 1) >= ERR_THRESH) && !cfg_auto_off;

  // reference: seeded from data while hunting, free-running when locked
  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else if (bit_en)
      ref_q <= {ref_q[REF_W-2:0], (locked && !resync_rise) ? pred : bit_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      mcnt_q  <= '0;
      wcnt_q  <= '0;
      werr_q  <= '0;
    end else if (resync_rise) begin
      state_q <= ST_HUNT;
      mcnt_q  <= '0;
      wcnt_q  <= '0;
      werr_q  <= '0;
    end else if (bit_en) begin
      if (state_q == ST_HUNT) begin
        if (mismatch) mcnt_q <= '0;
        else if (mcnt_q == M_LAST) begin
          state_q <= ST_LOCK;
          mcnt_q  <= '0;
          wcnt_q  <= '0;
          werr_q  <= '0;
        end else mcnt_q <= mcnt_q + 1'b1;
      end else begin
        if (err_hit) begin
          state_q <= ST_HUNT;
          wcnt_q  <= '0;
          werr_q  <= '0;
        end else if (wcnt_q == W_LAST) begin
          wcnt_q <= '0;
          werr_q <= '0;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
          if (mismatch && werr_q != E_MAX) werr_q <= werr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/patrx_counters.sv
module patrx_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             mismatch,
  input  logic             latch_rise,
  output logic [CNT_W-1:0] bit_lat,
  output logic [CNT_W-1:0] err_lat
);
  logic [CNT_W-1:0] bit_q, err_q;
  logic             err_en;
  assign err_en = count_en & mismatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q   <= '0;
      err_q   <= '0;
      bit_lat <= '0;
      err_lat <= '0;
    end else if (latch_rise) begin
      bit_lat <= bit_q;
      err_lat <= err_q;
      bit_q   <= count_en ? CNT_W'(1) : '0;
      err_q   <= err_en ? CNT_W'(1) : '0;
    end else begin
      if (count_en && bit_q != '1) bit_q <= bit_q + 1'b1;
      if (err_en && err_q != '1)   err_q <= err_q + 1'b1;
    end
  end
endmodule

// File: rtl/patrx_top.sv
module patrx_top
  import patrx_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int SYNC_MATCHES = 32,
  parameter int WIN_LEN      = 64,
  parameter int ERR_THRESH   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             tx_bit,
  input  logic             cfg_loopback,
  input  logic             cfg_rx_invert,
  input  logic             cfg_auto_off,
  input  logic             cfg_prbs,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [LEN_W-1:0] cfg_tap,
  input  logic             resync_req,
  input  logic             latch_ctl,
  input  logic             latch_pin,
  input  logic             capture_ctl,
  input  logic             capture_pin,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count,
  output logic [REF_W-1:0] rx_capture,
  output logic             locked
);
  localparam int N_REQ = 3;

  logic             bit_d;
  logic [N_REQ-1:0] req_v, rise_v;
  logic             resync_rise, latch_rise, capture_rise;
  logic             count_en, mismatch;
  logic [REF_W-1:0] hist_q;

  assign rx_ready = 1'b1;
  assign bit_d    = (cfg_loopback ? tx_bit : rx_bit) ^ cfg_rx_invert;
  assign req_v    = {resync_req, latch_ctl | latch_pin, capture_ctl | capture_pin};

  for (genvar g = 0; g < N_REQ; g++) begin : g_rise
    patrx_rise u_rise (.clk(clk), .rst_n(rst_n), .req(req_v[g]), .rise(rise_v[g]));
  end
  assign resync_rise  = rise_v[2];
  assign latch_rise   = rise_v[1];
  assign capture_rise = rise_v[0];

  patrx_sync #(
    .SYNC_MATCHES(SYNC_MATCHES), .WIN_LEN(WIN_LEN), .ERR_THRESH(ERR_THRESH)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_valid), .bit_in(bit_d),
    .cfg_prbs(cfg_prbs), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
    .cfg_auto_off(cfg_auto_off), .resync_rise(resync_rise),
    .locked(locked), .count_en(count_en), .mismatch(mismatch)
  );

  patrx_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .mismatch(mismatch),
    .latch_rise(latch_rise), .bit_lat(bit_count), .err_lat(err_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q     <= '0;
      rx_capture <= '0;
    end else begin
      if (rx_valid)     hist_q     <= {hist_q[REF_W-2:0], bit_d};
      if (capture_rise) rx_capture <= hist_q;
    end
  end
endmodule

// File: rtl/patrx_top_chk.sv
module patrx_top_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             locked,
  input logic             resync_rise,
  input logic             latch_rise,
  input logic             capture_rise,
  input logic [CNT_W-1:0] bit_count,
  input logic [CNT_W-1:0] err_count,
  input logic [31:0]      rx_capture
);
  assert_resync_drops_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_rise |=> !locked);
  assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rx_valid));
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(bit_count) && $stable(err_count));
  assert_err_not_above_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= bit_count);
  assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_rise |=> $stable(rx_capture));
endmodule

bind patrx_top patrx_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .locked(locked),
  .resync_rise(resync_rise), .latch_rise(latch_rise), .capture_rise(capture_rise),
  .bit_count(bit_count), .err_count(err_count), .rx_capture(rx_capture)
);

// File: tb/patrx_top_tb_top.sv
`timescale 1ns/1ps
module patrx_top_tb_top;
  localparam logic [7:0] PAT = 8'hB4;
  localparam int SAT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 0, rx_valid = 0, tx_bit = 0;
  logic cfg_loopback = 0, cfg_rx_invert = 0, cfg_auto_off = 0, cfg_prbs = 0;
  logic [4:0] cfg_len = 5'd7, cfg_tap = 5'd0;
  logic resync_req = 0, latch_ctl = 0, latch_pin = 0, capture_ctl = 0, capture_pin = 0;
  logic rx_ready, locked, sat_ready, sat_locked;
  logic [31:0] bit_count, err_count, rx_capture, sat_capture;
  logic [SAT_W-1:0] sat_bits, sat_errs;

  always #2.5 clk = ~clk;

  patrx_top dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_bit(tx_bit), .cfg_loopback(cfg_loopback), .cfg_rx_invert(cfg_rx_invert),
    .cfg_auto_off(cfg_auto_off), .cfg_prbs(cfg_prbs), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
    .resync_req(resync_req), .latch_ctl(latch_ctl), .latch_pin(latch_pin),
    .capture_ctl(capture_ctl), .capture_pin(capture_pin),
    .bit_count(bit_count), .err_count(err_count), .rx_capture(rx_capture), .locked(locked));

  patrx_top #(.CNT_W(SAT_W)) sat_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_ready(sat_ready),
    .tx_bit(tx_bit), .cfg_loopback(cfg_loopback), .cfg_rx_invert(cfg_rx_invert),
    .cfg_auto_off(cfg_auto_off), .cfg_prbs(cfg_prbs), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
    .resync_req(resync_req), .latch_ctl(latch_ctl), .latch_pin(latch_pin),
    .capture_ctl(capture_ctl), .capture_pin(capture_pin),
    .bit_count(sat_bits), .err_count(sat_errs), .rx_capture(sat_capture), .locked(sat_locked));

  typedef enum int {S_BITS, S_ERRS, S_CAP, S_LOCK, S_SBITS, S_SERRS, S_READY} sel_e;
  typedef struct { sel_e sel; logic [31:0] val; string req; } item_t;
  item_t exp_q[$];

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] hist_m = '0;
  int cnt_b = 0, cnt_e = 0, lat_b = 0, lat_e = 0, pidx = 0;
  bit counting = 0, use_prbs = 0;
  logic [6:0] lfsr = 7'b0000001;

  task automatic expect_item(input sel_e s, input logic [31:0] v, input string r);
    item_t it;
    it.sel = s; it.val = v; it.req = r;
    exp_q.push_back(it);
  endtask

  // monitor: compares queued expectations after each edge
  initial begin
    forever begin
      @(posedge clk); #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        case (it.sel)
          S_BITS:  act = bit_count;
          S_ERRS:  act = err_count;
          S_CAP:   act = rx_capture;
          S_LOCK:  act = {31'd0, locked};
          S_SBITS: act = {26'd0, sat_bits};
          S_SERRS: act = {26'd0, sat_errs};
          default: act = {31'd0, rx_ready};
        endcase
        n_tests++;
        if (act !== it.val) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic gen_bit(input bit flip, output logic d);
    logic b;
    if (use_prbs) begin b = lfsr[6] ^ lfsr[5]; lfsr = {lfsr[5:0], b}; end
    else begin b = PAT[pidx % 8]; pidx++; end
    d = b ^ flip;
    if (counting) begin cnt_b++; if (flip ^ cfg_rx_invert) cnt_e++; end
  endtask

  task automatic apply_bit(input logic d);
    rx_valid = 1'b1;
    if (cfg_loopback) begin tx_bit = d; rx_bit = ~d; end
    else begin rx_bit = d; tx_bit = ~d; end
    hist_m = {hist_m[30:0], d ^ cfg_rx_invert};
  endtask

  task automatic send(input int n, input bit flip);
    for (int i = 0; i < n; i++) begin
      logic d;
      gen_bit(flip, d);
      @(negedge clk);
      apply_bit(d);
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_latch();
    @(negedge clk); latch_pin = 1'b1;
    @(negedge clk); latch_pin = 1'b0;
    lat_b = cnt_b; lat_e = cnt_e; cnt_b = 0; cnt_e = 0;
  endtask

  task automatic do_capture();
    @(negedge clk); capture_pin = 1'b1;
    @(negedge clk); capture_pin = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_item(S_BITS, 0, "R1"); expect_item(S_ERRS, 0, "R1");
    expect_item(S_CAP, 0, "R1");  expect_item(S_LOCK, 0, "R1");
    expect_item(S_READY, 1, "R11"); settle();

    // R2 lock takes at least 32 matches, then holds
    send(20, 0); expect_item(S_LOCK, 0, "R2 early"); settle();
    send(80, 0); expect_item(S_LOCK, 1, "R2 lock"); settle();
    do_latch(); counting = 1;

    // R3/R4 counts with three errors
    send(5, 0); send(1, 1); send(11, 0); send(1, 1); send(12, 0); send(1, 1); send(9, 0);
    do_latch();
    expect_item(S_BITS, lat_b, "R3 bits"); expect_item(S_ERRS, lat_e, "R4 errs");
    expect_item(S_BITS, 40, "R3 bits=40"); expect_item(S_ERRS, 3, "R4 errs=3"); settle();

    // R6 capture via register source; R5 held source does nothing
    @(negedge clk); capture_ctl = 1'b1; @(negedge clk);
    expect_item(S_CAP, hist_m, "R6 capture"); settle();
    begin
      logic [31:0] held;
      held = hist_m;
      send(5, 0);
      @(negedge clk); capture_pin = 1'b1; @(negedge clk);
      expect_item(S_CAP, held, "R5 capture no re-arm"); settle();
      capture_ctl = 1'b0; capture_pin = 1'b0; @(negedge clk);
    end
    do_capture(); expect_item(S_CAP, hist_m, "R5 capture pin"); settle();

    // R5 latch held high
    @(negedge clk); latch_ctl = 1'b1; @(negedge clk);
    lat_b = cnt_b; cnt_b = 0; cnt_e = 0;
    expect_item(S_BITS, 5, "R5 latch ctl"); settle();
    send(10, 0);
    @(negedge clk); latch_pin = 1'b1; @(negedge clk);
    expect_item(S_BITS, 5, "R5 latch no re-arm"); settle();
    latch_ctl = 1'b0; latch_pin = 1'b0; @(negedge clk);
    do_latch(); expect_item(S_BITS, 10, "R5 latch pin"); settle();

    // R3 collision: latch edge with an accepted bit
    send(10, 0);
    begin
      logic d;
      gen_bit(1'b0, d);
      @(negedge clk); apply_bit(d); latch_pin = 1'b1;
      @(negedge clk); rx_valid = 1'b0; latch_pin = 1'b0;
      cnt_b = 1; cnt_e = 0;
    end
    expect_item(S_BITS, 10, "R3 collision old"); settle();
    do_latch(); expect_item(S_BITS, 1, "R3 collision new"); settle();

    // R7 inversion, auto resync off
    cfg_auto_off = 1'b1; cfg_rx_invert = 1'b1; @(negedge clk);
    send(32, 0); do_latch(); do_capture();
    expect_item(S_ERRS, 32, "R7 inverted errors"); expect_item(S_BITS, 32, "R7 bits");
    expect_item(S_CAP, hist_m, "R7 inverted capture"); settle();
    cfg_rx_invert = 1'b0; @(negedge clk);

    // R4 saturation
    do_latch(); send(70, 1); do_latch();
    expect_item(S_BITS, 70, "R4 bits 70"); expect_item(S_ERRS, 70, "R4 errs 70");
    expect_item(S_SBITS, 63, "R4 sat bits"); expect_item(S_SERRS, 63, "R4 sat errs"); settle();

    // R9 auto resync off / on
    send(12, 1); expect_item(S_LOCK, 1, "R9 auto off keeps lock"); settle();
    cfg_auto_off = 1'b0; @(negedge clk);
    send(12, 1); expect_item(S_LOCK, 0, "R9 auto resync"); settle();
    counting = 0; do_latch();

    // R4 no counting while hunting
    send(10, 0); do_latch(); expect_item(S_BITS, 0, "R4 hunt no count"); settle();
    send(60, 0); expect_item(S_LOCK, 1, "R2 relock"); settle();

    // R10 manual resync, held high
    @(negedge clk); resync_req = 1'b1; @(negedge clk);
    expect_item(S_LOCK, 0, "R10 resync"); settle();
    send(80, 0); expect_item(S_LOCK, 1, "R10 relock"); settle();
    send(5, 0); expect_item(S_LOCK, 1, "R5 resync no re-arm"); settle();
    resync_req = 1'b0; @(negedge clk);
    do_latch(); counting = 1; do_latch();

    // R8 loopback ignores rx_bit
    cfg_loopback = 1'b1; @(negedge clk);
    send(20, 0); do_latch(); do_capture();
    expect_item(S_BITS, 20, "R8 loop bits"); expect_item(S_ERRS, 0, "R8 loop errs");
    expect_item(S_CAP, hist_m, "R8 loop capture"); expect_item(S_LOCK, 1, "R8 lock"); settle();
    cfg_loopback = 1'b0; @(negedge clk);

    // R2 pseudorandom x^7+x^6+1
    counting = 0; use_prbs = 1; cfg_prbs = 1'b1; cfg_len = 5'd6; cfg_tap = 5'd5;
    @(negedge clk); resync_req = 1'b1; @(negedge clk); resync_req = 1'b0;
    send(120, 0); expect_item(S_LOCK, 1, "R2 prbs lock"); settle();
    do_latch(); counting = 1; send(30, 0); do_latch();
    expect_item(S_BITS, 30, "R2 prbs bits"); expect_item(S_ERRS, 0, "R2 prbs errs"); settle();

    settle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule